// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the bus cycles of a processor whose 16 data lines share pins with the low half of a 20-bit address. The upper four address lines carry cycle status once the address phase is over. A requester presents one read or write at a time. Each request carries a memory/IO select, a byte-high enable, a segment tag and the current interrupt-enable flag. The sequencer walks the cycle through the states ADDR (T1), STRB (T2), SMPL (T3), zero or more WAIT states, and DONE (T4). Along the way it produces the address strobe, the shared-bus drive and its output enable, and the direction and data-buffer controls. It also produces the active-low read and write strobes. Read data is captured from the bus input and returned with a one-cycle valid pulse.

Between cycles the sequencer sits in IDLE. An external master may claim the bus by raising `hold`. The sequencer then moves to HOLD, raises `hlda` and releases every bus output. While `hold` stays high, no new cycle starts. The transitions are as follows. IDLE goes to ADDR on an accepted request and to HOLD on hold. ADDR goes to STRB. STRB goes to SMPL. SMPL goes to DONE when ready is high and to WAIT otherwise. WAIT goes to DONE when ready is high and stays in WAIT otherwise. DONE goes to HOLD on hold, to ADDR on a pending request, and to IDLE otherwise. HOLD goes to IDLE when hold drops.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `hlda`=0, `ad_oe`=0, `ctl_oe`=1, `rdata_valid`=0.
- R2: In the first cycle after acceptance (T1), `ale`=1 for exactly one cycle, `ad_oe`=1, `ad_out`=address[15:0] and `as_out`=address[19:16].
- R3: From T2 through T4, `as_out` carries status. Bit 3 is always 0, bit 2 is the interrupt-enable flag captured at acceptance, and bits 1:0 are the segment tag (00 extra, 01 stack, 10 code/none, 11 data).
- R4: `m_io` (1 = memory, 0 = I/O), `dt_r` (1 = write/transmit, 0 = read/receive) and `bhe_n` (0 = high byte enabled) hold one value from T1 through T4.
- R5: In a read, `ad_oe`=0 from T2 through T4. `rd_n` and `den_n` are low in T2, T3 and every wait state, and high in T4. `ad_in` is captured on the edge that leaves T3 or the last wait state, and appears on `rdata` with `rdata_valid`=1 during T4.
- R6: In a write, `ad_out` carries the write data with `ad_oe`=1 from T2 through T4. `wr_n` is low in T2, T3 and every wait state. `den_n` is low from T2 through T4.
- R7: When `ready` is low at the edge ending T3 or a wait state, another wait state follows. With `ready` high the cycle moves to T4, so a cycle lasts 4 + waits clocks.
- R8: `hold` high at the edge ending IDLE or T4 makes `hlda` high in the next cycle. `hold` raised during T1–T3 lets the current cycle finish first. No T1 starts while `hold` is high.
- R9: While `hlda` is high, `ad_oe`=0 and `ctl_oe`=0, which releases address/data, status, `bhe_n`, `m_io`, `dt_r`, `rd_n`, `wr_n` and `den_n`.
- R10: When `hold` is low at an edge in HOLD, `hlda` is low in the next cycle. A pending request is then accepted and its T1 follows one cycle later.
- R11: A request pending in T4 with `hold` low is accepted there, and its T1 directly follows T4.
- R12: `req_ack` is high only in a cycle where the request is taken (IDLE or T4, `hold` low, `req_valid` high), and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_addr | input | 20 | Cycle address |
| req_bhe_n | input | 1 | Byte-high enable for the cycle (active low) |
| req_seg | input | 2 | Segment tag for status bits 1:0 |
| req_wdata | input | 16 | Write data |
| int_en | input | 1 | Interrupt-enable flag for status bit 2 |
| req_ack | output | 1 | Request accepted this cycle |
| ready | input | 1 | Slave ready; low inserts wait states |
| hold | input | 1 | External master bus request |
| hlda | output | 1 | Bus granted to external master |
| ad_in | input | 16 | Shared bus input |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | `rdata` valid (one cycle, T4) |
| ale | output | 1 | Address latch strobe |
| ad_out | output | 16 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| as_out | output | 4 | Upper address / status lines |
| ctl_oe | output | 1 | Enable for status and control outputs |
| bhe_n | output | 1 | Byte-high enable |
| m_io | output | 1 | Memory (1) or I/O (0) |
| dt_r | output | 1 | Transmit (1) or receive (0) |
| den_n | output | 1 | Data buffer enable (active low) |
| rd_n | output | 1 | Read strobe (active low) |
| wr_n | output | 1 | Write strobe (active low) |

## Verification
The hardest situation to reach is a hold request that arrives in the middle of a cycle. Here the sequencer must let a write with a wait state finish with all strobes intact and grant the bus only after T4. The stimulus tracks the address strobe to find T1. It raises `hold` on the falling edge inside T2 and then watches `hlda` stay low through T3, the wait state and T4 before it rises. A second hard case is a request that waits behind a granted hold. It is queued while `hlda` is high and must start exactly one cycle after the grant drops. A bus model with a programmable ready delay supplies the wait states. A scoreboard checks strobe lengths, the status nibble and the data of every cycle against the queued requests.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_STRB = 3'd2,
        ST_SMPL = 3'd3,
        ST_WAIT = 3'd4,
        ST_DONE = 3'd5,
        ST_HOLD = 3'd6
    } bus_state_e;

    localparam logic [1:0] SEG_EXTRA = 2'b00;
    localparam logic [1:0] SEG_STACK = 2'b01;
    localparam logic [1:0] SEG_CODE  = 2'b10;
    localparam logic [1:0] SEG_DATA  = 2'b11;

    function automatic logic in_strobe(input bus_state_e s);
        return (s == ST_STRB) || (s == ST_SMPL) || (s == ST_WAIT);
    endfunction

endpackage

// File: rtl/mbus_req_reg.sv
module mbus_req_reg #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic              in_mem,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_bhe_n,
    input  logic [1:0]        in_seg,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_ie,
    output logic              cur_write,
    output logic              cur_mem,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_bhe_n,
    output logic [1:0]        cur_seg,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_ie
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_write <= 1'b0;
            cur_mem   <= 1'b0;
            cur_addr  <= '0;
            cur_bhe_n <= 1'b1;
            cur_seg   <= 2'b00;
            cur_wdata <= '0;
            cur_ie    <= 1'b0;
        end else if (load) begin
            cur_write <= in_write;
            cur_mem   <= in_mem;
            cur_addr  <= in_addr;
            cur_bhe_n <= in_bhe_n;
            cur_seg   <= in_seg;
            cur_wdata <= in_wdata;
            cur_ie    <= in_ie;
        end
    end

endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       hold,
    output bus_state_e state,
    output logic       accept
);

    bus_state_e state_nx;
    logic       open_slot;

    assign open_slot = (state == ST_IDLE) || (state == ST_DONE);
    assign accept    = open_slot && !hold && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (hold)           state_nx = ST_HOLD;
                else if (req_valid) state_nx = ST_ADDR;
            end
            ST_ADDR: state_nx = ST_STRB;
            ST_STRB: state_nx = ST_SMPL;
            ST_SMPL: state_nx = ready ? ST_DONE : ST_WAIT;
            ST_WAIT: state_nx = ready ? ST_DONE : ST_WAIT;
            ST_DONE: begin
                if (hold)           state_nx = ST_HOLD;
                else if (req_valid) state_nx = ST_ADDR;
                else                state_nx = ST_IDLE;
            end
            ST_HOLD: begin
                if (!hold)          state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  bus_state_e               state,
    input  logic                     cur_write,
    input  logic                     cur_mem,
    input  logic [ADDR_W-1:0]        cur_addr,
    input  logic                     cur_bhe_n,
    input  logic [1:0]               cur_seg,
    input  logic [DATA_W-1:0]        cur_wdata,
    input  logic                     cur_ie,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     ctl_oe,
    output logic                     bhe_n,
    output logic                     m_io,
    output logic                     dt_r,
    output logic                     den_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     hlda
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] status;

    always_comb begin
        status    = '0;
        status[1:0] = cur_seg;
        status[2]   = cur_ie;
    end

    always_comb begin
        ale    = 1'b0;
        ad_out = '0;
        ad_oe  = 1'b0;
        as_out = '0;
        ctl_oe = 1'b1;
        bhe_n  = cur_bhe_n;
        m_io   = cur_mem;
        dt_r   = cur_write;
        den_n  = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        hlda   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                bhe_n = 1'b1;
            end
            ST_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cur_addr[DATA_W-1:0];
                as_out = cur_addr[ADDR_W-1:DATA_W];
            end
            ST_STRB, ST_SMPL, ST_WAIT: begin
                as_out = status;
                den_n  = 1'b0;
                if (cur_write) begin
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                    wr_n   = 1'b0;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            ST_DONE: begin
                as_out = status;
                if (cur_write) begin
                    ad_oe  = 1'b1;
                    ad_out = cur_wdata;
                    den_n  = 1'b0;
                end
            end
            ST_HOLD: begin
                ctl_oe = 1'b0;
                bhe_n  = 1'b1;
                hlda   = 1'b1;
            end
            default: begin
                ctl_oe = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mbus_rdata_cap.sv
module mbus_rdata_cap
    import mbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              ready,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    logic take;

    assign take = ((state == ST_SMPL) || (state == ST_WAIT)) && ready && !cur_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= take;
            if (take) rdata <= ad_in;
        end
    end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_mem,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_bhe_n,
    input  logic [1:0]               req_seg,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     int_en,
    output logic                     req_ack,
    input  logic                     ready,
    input  logic                     hold,
    output logic                     hlda,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     ctl_oe,
    output logic                     bhe_n,
    output logic                     m_io,
    output logic                     dt_r,
    output logic                     den_n,
    output logic                     rd_n,
    output logic                     wr_n
);

    bus_state_e        state;
    logic              accept;
    logic              cur_write;
    logic              cur_mem;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_bhe_n;
    logic [1:0]        cur_seg;
    logic [DATA_W-1:0] cur_wdata;
    logic              cur_ie;

    assign req_ack = accept;

    mbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .hold      (hold),
        .state     (state),
        .accept    (accept)
    );

    mbus_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_write  (req_write),
        .in_mem    (req_mem),
        .in_addr   (req_addr),
        .in_bhe_n  (req_bhe_n),
        .in_seg    (req_seg),
        .in_wdata  (req_wdata),
        .in_ie     (int_en),
        .cur_write (cur_write),
        .cur_mem   (cur_mem),
        .cur_addr  (cur_addr),
        .cur_bhe_n (cur_bhe_n),
        .cur_seg   (cur_seg),
        .cur_wdata (cur_wdata),
        .cur_ie    (cur_ie)
    );

    mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .state     (state),
        .cur_write (cur_write),
        .cur_mem   (cur_mem),
        .cur_addr  (cur_addr),
        .cur_bhe_n (cur_bhe_n),
        .cur_seg   (cur_seg),
        .cur_wdata (cur_wdata),
        .cur_ie    (cur_ie),
        .ale       (ale),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .as_out    (as_out),
        .ctl_oe    (ctl_oe),
        .bhe_n     (bhe_n),
        .m_io      (m_io),
        .dt_r      (dt_r),
        .den_n     (den_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .hlda      (hlda)
    );

    mbus_rdata_cap #(.DATA_W(DATA_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .ready       (ready),
        .cur_write   (cur_write),
        .ad_in       (ad_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     hold,
    input logic                     hlda,
    input logic                     req_ack,
    input logic                     ale,
    input logic                     ad_oe,
    input logic                     ctl_oe,
    input logic [ADDR_W-DATA_W-1:0] as_out,
    input logic                     m_io,
    input logic                     dt_r,
    input logic                     rd_n,
    input logic                     wr_n
);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_status_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (as_out[ADDR_W-DATA_W-1] == 1'b0));

    assert_ctl_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> ($stable(m_io) && $stable(dt_r)));

    assert_read_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_grant_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));

    assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && hlda) |=> !ale);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !ctl_oe));

    assert_grant_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold) |=> !hlda);

    assert_ack_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .hlda    (hlda),
    .req_ack (req_ack),
    .ale     (ale),
    .ad_oe   (ad_oe),
    .ctl_oe  (ctl_oe),
    .as_out  (as_out),
    .m_io    (m_io),
    .dt_r    (dt_r),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
);

// File: tb/test_mbus_cycle_seq.sv
`timescale 1ns/100ps
module test_mbus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_bhe_n = 1'b1;
    logic [1:0]  req_seg = 2'b00;
    logic [15:0] req_wdata = '0;
    logic        int_en = 1'b0;
    logic        req_ack;
    logic        ready = 1'b0;
    logic        hold = 1'b0;
    logic        hlda;
    logic [15:0] ad_in;
    logic [15:0] rdata;
    logic        rdata_valid;
    logic        ale;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  as_out;
    logic        ctl_oe;
    logic        bhe_n;
    logic        m_io;
    logic        dt_r;
    logic        den_n;
    logic        rd_n;
    logic        wr_n;

    always #2.5 clk = ~clk;

    mbus_cycle_seq i_mbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_addr(req_addr), .req_bhe_n(req_bhe_n),
        .req_seg(req_seg), .req_wdata(req_wdata), .int_en(int_en),
        .req_ack(req_ack), .ready(ready), .hold(hold), .hlda(hlda),
        .ad_in(ad_in), .rdata(rdata), .rdata_valid(rdata_valid), .ale(ale),
        .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .ctl_oe(ctl_oe),
        .bhe_n(bhe_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_f(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3};
    endfunction

    // bus slave model: latches address, answers reads, paces ready
    logic [19:0] lat_addr = '0;
    int          wait_cfg = 0;
    int          lo_cnt   = 0;
    assign ad_in = (!rd_n && ctl_oe) ? mem_f(lat_addr) : 16'h0000;

    always @(negedge clk) begin
        if (ale) lat_addr = {as_out, ad_out};
        if (ctl_oe && (!rd_n || !wr_n)) lo_cnt = lo_cnt + 1;
        else lo_cnt = 0;
        ready = (lo_cnt >= 2 + wait_cfg);
    end

    // scoreboard
    typedef struct packed {
        logic [19:0] addr;
        logic        wr;
        logic        mem;
        logic        bhe_n;
        logic [3:0]  stat;
        logic [15:0] data;
        logic [7:0]  waits;
    } exp_t;

    exp_t sb_q[$];

    task automatic issue(input logic wr, input logic mem, input logic [19:0] addr,
                         input logic bhe, input logic [1:0] seg, input logic ie,
                         input logic [15:0] wd, input int waits);
        exp_t e;
        @(negedge clk);
        req_write = wr; req_mem = mem; req_addr = addr; req_bhe_n = bhe;
        req_seg = seg; int_en = ie; req_wdata = wd; wait_cfg = waits;
        req_valid = 1'b1;
        #1;
        while (!req_ack) begin
            @(negedge clk);
            #1;
        end
        e.addr = addr; e.wr = wr; e.mem = mem; e.bhe_n = bhe;
        e.stat = {1'b0, ie, seg};
        e.data = wr ? wd : mem_f(addr);
        e.waits = 8'(waits);
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(req_ack == 1'b0, "R12 ack not repeated in T1", 32'(req_ack), 32'h0);
    endtask

    // monitor
    bit          in_cyc = 1'b0;
    int          cyc, rdlo, wrlo, denlo;
    logic [19:0] m_addr;
    logic        m_wr, m_mio, m_bhe, seen_wd, oe_bad, stab_bad;
    logic [3:0]  m_stat;
    logic [15:0] m_wd;

    always @(negedge clk) begin
        if (ale) begin
            in_cyc = 1'b1; cyc = 1; m_addr = {as_out, ad_out};
            m_mio = m_io; m_wr = dt_r; m_bhe = bhe_n;
            rdlo = 0; wrlo = 0; denlo = 0; seen_wd = 1'b0;
            oe_bad = !ad_oe; stab_bad = 1'b0; m_stat = 4'hF; m_wd = '0;
        end else if (in_cyc) begin
            cyc = cyc + 1;
            if (cyc == 2) m_stat = as_out;
            if (m_io != m_mio || dt_r != m_wr || bhe_n != m_bhe) stab_bad = 1'b1;
            if (!rd_n) rdlo = rdlo + 1;
            if (!wr_n) begin
                wrlo = wrlo + 1;
                if (!seen_wd) begin m_wd = ad_out; seen_wd = 1'b1; end
            end
            if (!den_n) denlo = denlo + 1;
            if (m_wr ? !ad_oe : ad_oe) oe_bad = 1'b1;
            if (rd_n && wr_n && (rdlo + wrlo) > 0) begin
                exp_t e;
                in_cyc = 1'b0;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected cycle", 32'(m_addr), 32'h0);
                end else begin
                    e = sb_q.pop_front();
                    check(m_addr == e.addr, "R2 address in T1", 32'(m_addr), 32'(e.addr));
                    check(m_stat == e.stat, "R3 status nibble", 32'(m_stat), 32'(e.stat));
                    check(m_mio == e.mem && m_wr == e.wr && m_bhe == e.bhe_n && !stab_bad,
                          "R4 m_io/dt_r/bhe_n held", {29'h0, m_mio, m_wr, m_bhe},
                          {29'h0, e.mem, e.wr, e.bhe_n});
                    check(cyc == 4 + int'(e.waits), "R7 cycle length", 32'(cyc), 32'(4 + int'(e.waits)));
                    check(!oe_bad, "R5 R6 bus drive enable", 32'(oe_bad), 32'h0);
                    if (e.wr) begin
                        check(wrlo == 2 + int'(e.waits) && rdlo == 0, "R6 wr_n low length",
                              32'(wrlo), 32'(2 + int'(e.waits)));
                        check(denlo == 3 + int'(e.waits), "R6 den_n low length",
                              32'(denlo), 32'(3 + int'(e.waits)));
                        check(m_wd == e.data && ad_out == e.data, "R6 write data",
                              32'(m_wd), 32'(e.data));
                    end else begin
                        check(rdlo == 2 + int'(e.waits) && wrlo == 0, "R5 rd_n low length",
                              32'(rdlo), 32'(2 + int'(e.waits)));
                        check(denlo == 2 + int'(e.waits), "R5 den_n low length",
                              32'(denlo), 32'(2 + int'(e.waits)));
                        check(rdata_valid && rdata == e.data, "R5 read data",
                              {15'h0, rdata_valid, rdata}, {15'h1, e.data});
                    end
                end
            end
        end
    end

    task automatic drain();
        while (sb_q.size() != 0 || in_cyc) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        check(!ale && rd_n && wr_n && den_n && !hlda && !ad_oe && ctl_oe && !rdata_valid,
              "R1 idle after reset",
              {25'h0, ale, rd_n, wr_n, den_n, hlda, ad_oe, ctl_oe},
              {25'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});

        // main function: reads and writes with varied waits, segments, targets
        issue(1'b0, 1'b1, 20'hA1234, 1'b0, mbus_pkg::SEG_DATA,  1'b1, 16'h0000, 0);
        drain();
        issue(1'b1, 1'b0, 20'h0BEEF, 1'b1, mbus_pkg::SEG_STACK, 1'b1, 16'hC0DE, 2);
        drain();
        issue(1'b0, 1'b1, 20'hF0F01, 1'b1, mbus_pkg::SEG_EXTRA, 1'b0, 16'h0000, 3);
        drain();
        issue(1'b1, 1'b1, 20'h5A5A4, 1'b0, mbus_pkg::SEG_CODE,  1'b0, 16'h1357, 0);
        drain();

        // R11 back-to-back cycles
        issue(1'b1, 1'b1, 20'h11110, 1'b0, mbus_pkg::SEG_DATA, 1'b0, 16'hAAAA, 0);
        fork
            issue(1'b0, 1'b0, 20'h22222, 1'b1, mbus_pkg::SEG_STACK, 1'b1, 16'h0000, 0);
        join_none
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #2;
            check(!ale, "R11 no strobe before T4 ends", 32'(ale), 32'h0);
        end
        @(negedge clk); #2;
        check(ale, "R11 T1 directly after T4", 32'(ale), 32'h1);
        drain();

        // R8 R9 R10 hold in idle with a request waiting
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk); #2;
        check(hlda, "R8 hlda one clock after hold", 32'(hlda), 32'h1);
        check(!ad_oe && !ctl_oe, "R9 outputs released", {30'h0, ad_oe, ctl_oe}, 32'h0);
        fork
            issue(1'b0, 1'b1, 20'h3C3C3, 1'b0, mbus_pkg::SEG_CODE, 1'b1, 16'h0000, 1);
        join_none
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #2;
            check(!ale && !req_ack && hlda, "R8 no start under hold",
                  {29'h0, ale, req_ack, hlda}, 32'h1);
        end
        @(negedge clk);
        hold = 1'b0;
        @(negedge clk); #2;
        check(!hlda && req_ack, "R10 hlda drops, request taken",
              {30'h0, hlda, req_ack}, 32'h1);
        @(negedge clk); #2;
        check(ale, "R10 T1 after grant drops", 32'(ale), 32'h1);
        drain();

        // R8 hold raised mid-cycle: current write completes first
        fork
            issue(1'b1, 1'b0, 20'h0F00D, 1'b0, mbus_pkg::SEG_EXTRA, 1'b0, 16'hBEAD, 1);
        join_none
        @(negedge clk); #2;
        while (!ale) begin @(negedge clk); #2; end
        @(negedge clk);
        hold = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #2;
            check(!hlda && ctl_oe, "R8 cycle finishes before grant",
                  {30'h0, hlda, ctl_oe}, 32'h1);
        end
        @(negedge clk); #2;
        check(hlda && !ctl_oe && !ad_oe, "R8 R9 grant after T4",
              {29'h0, hlda, ctl_oe, ad_oe}, 32'h4);
        hold = 1'b0;
        @(negedge clk); #2;
        check(!hlda, "R10 release after hold drops", 32'(hlda), 32'h0);
        drain();
        check(sb_q.size() == 0, "R12 every accepted request completed", 32'(sb_q.size()), 32'h0);

        finish_run();
    end

endmodule